// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is the byte shifter behind a two-wire (SCL/SDA) serial port. It can take either bus role. It holds an 8-bit data register and a 4-bit edge counter that advances on every SCL edge. It has two sticky flags, one for a start condition and one for counter overflow, and a slave-side clock-hold machine that keeps SCL low. Both bus lines are open-drain. The block drives each line through a drive-low enable and reads each line back through an input.

The block does not frame bytes, match addresses or decide acknowledges. Software does all of that through four register addresses. Software loads the data register, presets the counter and clears the flags, and in master mode it toggles the SCL drive itself, one edge per write. Once the edges happen, the shifting runs in hardware: the line is sampled on each SCL rise and shifted in on each fall. A counter preset of 0 ends a transfer after 8 bits, and a preset of 14 ends it after one bit, which suits an acknowledge.

The hold machine has three states:
- `HOLD_RELEASE`: SCL is not held.
- `HOLD_START`: the start flag is set.
- `HOLD_OVF`: the overflow flag is set and the start flag is clear.

The next state is computed from the flags in every state:
- start flag set → `HOLD_START`;
- otherwise overflow flag set → `HOLD_OVF`;
- otherwise → `HOLD_RELEASE`.

In master mode the next state is always `HOLD_RELEASE`.

Top module: `twi_shift_unit`

## Requirements
- R1: After reset, STATUS (address 1) reads 0x30, DATA (address 0) reads 0xFF, CTRL (address 2) reads 0x00, and `scl_low` and `sda_low` are both 0.
- R2: Writing CTRL sets the mode from bit 1 (1 = slave). Writing a 1 in CTRL bit 0 inverts the master clock drive, which CTRL bit 0 reads back. In master mode `scl_low` follows that bit and changes only on such writes.
- R3: `sda_low` is 1 exactly when DATA bit 7 is 0.
- R4: The SDA line is captured on each SCL rise and shifted into DATA bit 0 on the next SCL fall. After 8 bit periods DATA holds the 8 captured bits, first bit in bit 7.
- R5: Each SCL edge, rising or falling, increments the counter (STATUS bits 3:0). A wrap from 15 to 0 sets the overflow flag (STATUS bit 6). Any STATUS write loads the counter from write bits 3:0.
- R6: SDA falling while SCL is high sets the start flag (STATUS bit 7) and clears the counter.
- R7: Writing 1 to STATUS bit 7 or bit 6 clears that flag. Writing 0 to either bit leaves it unchanged.
- R8: In slave mode `scl_low` is 1 from the cycle after either flag is set until the cycle after both are clear. In master mode the flags never drive `scl_low`.
- R9: STATUS bit 5 reads the sampled SCL level and bit 4 the sampled SDA level, so a held or stretched clock can be seen.
- R10: When events coincide, setting a flag wins over clearing it, a start's counter clear wins over a counter preset, and a software write wins over an increment or a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address (0 DATA, 1 STATUS, 2 CTRL) |
| reg_wdata | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_low | output | 1 | Drive SCL low |
| sda_low | output | 1 | Drive SDA low |

## Verification
Detecting a start condition and clearing the start flag by a STATUS write can fall in the same cycle. The bench provokes this by pulling SDA low while SCL is high. It times the write so that it lands on the edge at which the synchronized falling SDA is acted on, one cycle after the sampling stage captures it. It then expects the start flag still set and the counter at 0, not at the value that was written.

// File: rtl/twi_su_pkg.sv
package twi_su_pkg;
    typedef enum logic [1:0] {
        HOLD_RELEASE,
        HOLD_START,
        HOLD_OVF
    } hold_state_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt
);
    logic scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= scl_in;
            sda_q    <= sda_in;
            scl_prev <= scl_q;
            sda_prev <= sda_q;
        end
    end

    assign scl_rise  = scl_q & ~scl_prev;
    assign scl_fall  = ~scl_q & scl_prev;
    assign start_evt = scl_q & scl_prev & sda_prev & ~sda_q;
endmodule

// File: rtl/twi_shift_core.sv
module twi_shift_core #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              sda_q,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              stat_we,
    input  logic              clr_start,
    input  logic              clr_ovf,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              start_f,
    output logic              ovf_f
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic bit_latch;
    logic any_edge, ovf_evt;

    assign any_edge = scl_rise | scl_fall;
    assign ovf_evt  = any_edge & (cnt_q == CNT_MAX) & ~stat_we & ~start_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_latch <= 1'b1;
            data_q    <= '1;
            cnt_q     <= '0;
            start_f   <= 1'b0;
            ovf_f     <= 1'b0;
        end else begin
            if (scl_rise) bit_latch <= sda_q;

            if (data_we)       data_q <= data_wdata;
            else if (scl_fall) data_q <= {data_q[DATA_W-2:0], bit_latch};

            if (start_evt)     cnt_q <= '0;
            else if (stat_we)  cnt_q <= cnt_wdata;
            else if (any_edge) cnt_q <= cnt_q + 1'b1;

            if (start_evt)                 start_f <= 1'b1;
            else if (stat_we && clr_start) start_f <= 1'b0;

            if (ovf_evt)                   ovf_f <= 1'b1;
            else if (stat_we && clr_ovf)   ovf_f <= 1'b0;
        end
    end

    // R4
    shift_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && !data_we) |=> data_q[DATA_W-1:1] == $past(data_q[DATA_W-2:0]));

    // R5
    wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_edge && cnt_q == CNT_MAX && !stat_we && !start_evt) |=> (ovf_f && cnt_q == '0));

    // R6
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (start_f && cnt_q == '0));
endmodule

// File: rtl/twi_hold_fsm.sv
module twi_hold_fsm
    import twi_su_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode,
    input  logic start_f,
    input  logic ovf_f,
    output logic scl_hold
);
    hold_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_RELEASE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = HOLD_RELEASE;
        unique case (state_q)
            HOLD_RELEASE, HOLD_START, HOLD_OVF: begin
                if (!slave_mode)  state_d = HOLD_RELEASE;
                else if (start_f) state_d = HOLD_START;
                else if (ovf_f)   state_d = HOLD_OVF;
                else              state_d = HOLD_RELEASE;
            end
            default: state_d = HOLD_RELEASE;
        endcase
    end

    always_comb begin
        scl_hold = (state_q != HOLD_RELEASE);
    end

    // R8
    hold_engage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && (start_f || ovf_f)) |=> scl_hold);

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_f && !ovf_f) |=> !scl_hold);

    // R8
    hold_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode |=> !scl_hold);
endmodule

// File: rtl/twi_shift_unit.sv
module twi_shift_unit
    import twi_su_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_low,
    output logic              sda_low
);
    logic scl_q, sda_q, scl_rise, scl_fall, start_evt;
    logic data_we, stat_we, ctrl_we;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic start_f, ovf_f, scl_hold;
    logic master_low, slave_mode;
    logic wdata_unused;

    assign data_we = reg_we && reg_addr == A_DATA;
    assign stat_we = reg_we && reg_addr == A_STAT;
    assign ctrl_we = reg_we && reg_addr == A_CTRL;
    assign wdata_unused = ^reg_wdata[DATA_W-3:CNT_W];

    twi_line_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt)
    );

    twi_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .sda_q(sda_q), .data_we(data_we),
        .data_wdata(reg_wdata), .stat_we(stat_we),
        .clr_start(reg_wdata[DATA_W-1]), .clr_ovf(reg_wdata[DATA_W-2]),
        .cnt_wdata(reg_wdata[CNT_W-1:0]), .data_q(data_q), .cnt_q(cnt_q),
        .start_f(start_f), .ovf_f(ovf_f)
    );

    twi_hold_fsm u_hold (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .start_f(start_f), .ovf_f(ovf_f), .scl_hold(scl_hold)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_low <= 1'b0;
            slave_mode <= 1'b0;
        end else if (ctrl_we) begin
            slave_mode <= reg_wdata[1];
            if (reg_wdata[0]) master_low <= ~master_low;
        end
    end

    assign scl_low = slave_mode ? scl_hold : master_low;
    assign sda_low = ~data_q[DATA_W-1];

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_DATA: rd_data = data_q;
            A_STAT: begin
                rd_data[DATA_W-1]  = start_f;
                rd_data[DATA_W-2]  = ovf_f;
                rd_data[DATA_W-3]  = scl_q;
                rd_data[DATA_W-4]  = sda_q;
                rd_data[CNT_W-1:0] = cnt_q;
            end
            A_CTRL: begin
                rd_data[1] = slave_mode;
                rd_data[0] = master_low;
            end
            default: rd_data = '0;
        endcase
    end

    // R2
    master_clk_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && !slave_mode && !$past(slave_mode)) |=> $stable(scl_low));
endmodule

// File: tb/sim_twi_shift_unit.sv
module sim_twi_shift_unit;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic scl_low, sda_low;
    logic ext_scl_low = 1'b0;
    logic ext_sda_low = 1'b0;
    wire scl_line = !(scl_low || ext_scl_low);
    wire sda_line = !(sda_low || ext_sda_low);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .scl_in(scl_line), .sda_in(sda_line), .scl_low(scl_low), .sda_low(sda_low)
    );

    // {tx byte, external byte, expected DATA = wired-AND}
    localparam logic [23:0] VEC [4] = '{24'hA5FF_A5, 24'hFF3C_3C, 24'h0FF0_00, 24'hC3E7_C3};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(2'd1, v); chk("R1 status", v, 8'h30);
        rd(2'd0, v); chk("R1 data", v, 8'hFF);
        rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 lines", {6'd0, scl_low, sda_low}, 8'h00);

        // R2 master clock toggle, no autonomous clock
        wr(2'd2, 8'h01); idle(20);
        chk("R2 scl_low", {7'd0, scl_low}, 8'h01);
        rd(2'd2, v); chk("R2 ctrl", v, 8'h01);

        // R4 R5 vector walk
        for (int k = 0; k < 4; k++) begin
            wr(2'd1, 8'hC0);
            wr(2'd0, VEC[k][23:16]);
            for (int i = 7; i >= 0; i--) begin
                ext_sda_low = ~VEC[k][8+i];
                idle(2);
                wr(2'd2, 8'h01); idle(4);
                wr(2'd2, 8'h01); idle(4);
            end
            rd(2'd0, v); chk("R4 data", v, VEC[k][7:0]);
            rd(2'd1, v); chk("R5 ovf/cnt", v & 8'h4F, 8'h40);
            ext_sda_low = 1'b0;
        end

        // R3 SDA drive from DATA bit 7
        wr(2'd0, 8'h7F); chk("R3 low", {7'd0, sda_low}, 8'h01);
        wr(2'd0, 8'hFF); chk("R3 high", {7'd0, sda_low}, 8'h00);
        wr(2'd2, 8'h01); idle(4);

        // R9 stretched clock visible
        ext_scl_low = 1'b1; idle(4);
        rd(2'd1, v); chk("R9 scl sampled", v & 8'h20, 8'h00);
        ext_scl_low = 1'b0; idle(4);
        rd(2'd1, v); chk("R9 scl high", v & 8'h20, 8'h20);

        // R5 single-bit preset 14
        wr(2'd1, 8'hCE);
        wr(2'd2, 8'h01); idle(4);
        rd(2'd1, v); chk("R5 cnt15", v & 8'h4F, 8'h0F);
        wr(2'd2, 8'h01); idle(4);
        rd(2'd1, v); chk("R5 wrap", v & 8'h4F, 8'h40);

        // R7 W1C
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R7 zero keeps", v & 8'h40, 8'h40);
        wr(2'd1, 8'h40);
        rd(2'd1, v); chk("R7 one clears", v & 8'h40, 8'h00);

        // R6 start detection
        wr(2'd1, 8'h05);
        ext_sda_low = 1'b1; idle(4);
        rd(2'd1, v); chk("R6 start", v & 8'h8F, 8'h80);
        ext_sda_low = 1'b0; idle(3);
        wr(2'd1, 8'h80);

        // R8 slave hold from start
        wr(2'd2, 8'h02);
        chk("R8 no hold", {7'd0, scl_low}, 8'h00);
        ext_sda_low = 1'b1; idle(4);
        chk("R8 hold start", {7'd0, scl_low}, 8'h01);
        wr(2'd1, 8'h80);
        chk("R8 lag", {7'd0, scl_low}, 8'h01);
        idle(1);
        chk("R8 released", {7'd0, scl_low}, 8'h00);
        idle(3);
        ext_sda_low = 1'b0; idle(3);

        // R8 slave hold from overflow
        wr(2'd1, 8'h0F);
        ext_scl_low = 1'b1; idle(4);
        chk("R8 hold ovf", {7'd0, scl_low}, 8'h01);
        ext_scl_low = 1'b0; idle(3);
        rd(2'd1, v); chk("R9 held scl", v & 8'h60, 8'h40);
        wr(2'd1, 8'h40); idle(1);
        chk("R8 ovf released", {7'd0, scl_low}, 8'h00);
        idle(3);

        // R8 master mode ignores flags
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h0F);
        ext_scl_low = 1'b1; idle(4);
        ext_scl_low = 1'b0; idle(4);
        rd(2'd1, v); chk("R8 master flag", v & 8'h60, 8'h60);
        chk("R8 master no hold", {7'd0, scl_low}, 8'h00);
        wr(2'd1, 8'h40);

        // R10 start detection coincides with start-flag clear and preset
        wr(2'd1, 8'h07);
        ext_sda_low = 1'b1;
        @(posedge clk); @(negedge clk);
        wr(2'd1, 8'h83);
        rd(2'd1, v); chk("R10 collision", v & 8'h8F, 8'h80);
        ext_sda_low = 1'b0; idle(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule